// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and presents one request line to a processor. A rising edge on a line that is not masked records that line as pending. A fixed-priority resolver picks the lowest-numbered pending line, and the block raises its processor request when the pick outranks everything already being serviced.

The processor answers with two acknowledge pulses. The first pulse moves the chosen line from the pending set into the in-service set and drops the processor request. During the second pulse the block drives the line's vector number, which is a programmable base plus the line number. Software can rewrite the mask and the vector base. An end-of-interrupt strobe retires the highest-priority line that is in service, so a line of higher priority can interrupt a handler that is already running.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_out and vec_valid are 0, vec_out is 0, every mask bit is 0 (all lines enabled), the vector base is 32 and no line is pending or in service.
- R2: A 0-to-1 transition on an unmasked line, seen between two clock edges, makes that line pending. A line held at 1 becomes pending only once for each assertion.
- R3: While mask bit i is 1, a rising edge on line i is dropped. It raises no request, and it does not reappear when the mask bit is cleared later.
- R4: irq_out is 1 in the cycle after the clock edge that records a pending line, provided that line may be delivered (see R8). irq_out is 0 when no such line exists.
- R5: When several lines are pending, the line with the lowest index is delivered first.
- R6: An ack pulse with irq_out at 1 (first phase) marks the chosen line in service and removes it from the pending set. irq_out is 0 during the following acknowledge phase.
- R7: The ack pulse after a first phase is the second phase. During it, vec_valid is 1 and vec_out equals base plus line index, modulo 256. At all other times vec_valid is 0 and vec_out is 0.
- R8: While line h is the lowest-indexed line in service, only pending lines with an index below h can raise irq_out. Lines with an index of h or above wait.
- R9: A 1 on eoi clears the in-service bit with the lowest index. Pending lines that were waiting behind it can then raise irq_out in the next cycle.
- R10: wr_base loads base_din as the new vector base. wr_mask loads mask_din as the mask, where bit i set to 1 blocks line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| wr_mask | input | 1 | Load strobe for the mask |
| mask_din | input | 8 | New mask value, 1 blocks a line |
| wr_base | input | 1 | Load strobe for the vector base |
| base_din | input | 8 | New vector base |
| eoi | input | 1 | End of interrupt: retire the highest-priority line in service |
| ack | input | 1 | Acknowledge pulse from the processor, one cycle per phase |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector number, nonzero only during the second phase |
| vec_valid | output | 1 | High during the second acknowledge phase |

## Verification
A rising edge on irq_in is recorded at the next clock edge, and irq_out follows combinationally, so the bench drives the edge and checks irq_out one cycle later. The first ack pulse takes effect at the next edge. The bench therefore holds ack for a second cycle and checks both the dropped irq_out and the vector during that second cycle, since vec_out and vec_valid are combinational on ack. Effects of mask writes, base writes and eoi appear one edge after the strobe. All inputs change and all outputs are sampled on the falling clock edge.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N        = 8,
  parameter int VW       = 8,
  parameter int BASE_RST = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          wr_mask,
  input  logic [N-1:0]  mask_din,
  input  logic          wr_base,
  input  logic [VW-1:0] base_din,
  input  logic          eoi,
  input  logic          ack,
  output logic          irq_out,
  output logic [VW-1:0] vec_out,
  output logic          vec_valid
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  irq_q, mask_q, req_q, isr_q;
  logic [VW-1:0] base_q;
  logic [IW-1:0] act_idx;
  logic          ph_q;

  logic [N-1:0]  rise, elig, isr_top, allow, cand, pick, retire;
  logic [IW-1:0] pick_idx;
  logic          take;

  assign rise    = irq_in & ~irq_q & ~mask_q;
  assign elig    = req_q & ~mask_q;
  assign isr_top = isr_q & (~isr_q + N'(1));
  assign allow   = (isr_q == '0) ? '1 : (isr_top - N'(1));
  assign cand    = elig & allow;
  assign pick    = cand & (~cand + N'(1));
  assign retire  = eoi ? isr_top : '0;

  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (cand[i]) pick_idx = IW'(i);
  end

  assign take      = ack && !ph_q && (cand != '0);
  assign irq_out   = !ph_q && (cand != '0);
  assign vec_valid = ack && ph_q;
  assign vec_out   = vec_valid ? (base_q + VW'(act_idx)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= '0;
      mask_q  <= '0;
      req_q   <= '0;
      isr_q   <= '0;
      base_q  <= VW'(BASE_RST);
      act_idx <= '0;
      ph_q    <= 1'b0;
    end else begin
      irq_q <= irq_in;
      if (wr_mask) mask_q <= mask_din;
      if (wr_base) base_q <= base_din;
      req_q <= (req_q & ~(take ? pick : '0)) | rise;
      isr_q <= (isr_q & ~retire) | (take ? pick : '0);
      if (take) begin
        act_idx <= pick_idx;
        ph_q    <= 1'b1;
      end else if (vec_valid) begin
        ph_q    <= 1'b0;
      end
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack,
  input logic         eoi,
  input logic         irq_out,
  input logic         vec_valid,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] req_q,
  input logic [N-1:0] isr_q
);
  a_r4_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((req_q & ~mask_q) != '0));

  a_r6_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  a_r6_irq_drops_in_phase2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> !irq_out);

  a_r7_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  a_r9_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr_q != '0) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .irq_out(irq_out),
  .vec_valid(vec_valid), .mask_q(mask_q), .req_q(req_q), .isr_q(isr_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_mask = 1'b0;
  logic [7:0] mask_din = '0;
  logic       wr_base = 1'b0;
  logic [7:0] base_din = '0;
  logic       eoi = 1'b0;
  logic       ack = 1'b0;
  logic       irq_out;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_mask(wr_mask), .mask_din(mask_din),
    .wr_base(wr_base), .base_din(base_din), .eoi(eoi), .ack(ack),
    .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // {irq pattern, expected first line}
  localparam logic [15:0] TBL [6] = '{
    {8'h01, 8'd0}, {8'h80, 8'd7}, {8'h0C, 8'd2},
    {8'hF0, 8'd4}, {8'hA2, 8'd1}, {8'h50, 8'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] p);
    irq_in = p;
    step();
    irq_in = '0;
  endtask

  task automatic do_ack(input int exp_vec, input string tag);
    ack = 1'b1;
    step();
    chk({tag, " irq low in phase2"}, irq_out, 0);
    chk({tag, " vec_valid"}, vec_valid, 1);
    chk({tag, " vector"}, vec_out, exp_vec);
    step();
    ack = 1'b0;
    chk({tag, " vec cleared"}, vec_out, 0);
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  initial begin
    step(); step();
    chk("R1 irq_out reset", irq_out, 0);
    chk("R1 vec_valid reset", vec_valid, 0);
    chk("R1 vec_out reset", vec_out, 0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", irq_out, 0);

    foreach (TBL[k]) begin
      int left;
      pulse(TBL[k][15:8]);
      chk("R4 irq after edge", irq_out, 1);
      do_ack(32 + int'(TBL[k][7:0]), "R5 R7 table");
      do_eoi();
      left = 0;
      for (int j = 0; j < 8 && irq_out; j++) begin
        ack = 1'b1; step(); step(); ack = 1'b0;
        do_eoi();
        left++;
      end
      chk("R2 R5 remaining pending", left, $countones(TBL[k][15:8]) - 1);
    end

    // R2 held-high line triggers only once
    irq_in = 8'h08;
    step();
    chk("R2 held line raises", irq_out, 1);
    do_ack(35, "R2 held");
    do_eoi();
    step(); step();
    chk("R2 held line no retrigger", irq_out, 0);
    irq_in = '0;
    step();

    // R3 and R10 mask
    wr_mask = 1'b1; mask_din = 8'h04; step(); wr_mask = 1'b0;
    pulse(8'h04);
    chk("R3 masked edge dropped", irq_out, 0);
    wr_mask = 1'b1; mask_din = 8'h00; step(); wr_mask = 1'b0;
    chk("R3 no revival after unmask", irq_out, 0);

    // R8 nesting, R9 eoi order
    pulse(8'h10);
    do_ack(36, "R8 line4");
    pulse(8'h20);
    chk("R8 lower priority waits", irq_out, 0);
    pulse(8'h02);
    chk("R8 higher priority nests", irq_out, 1);
    do_ack(33, "R8 line1");
    do_eoi();
    chk("R9 line4 still in service", irq_out, 0);
    do_eoi();
    chk("R9 line5 released", irq_out, 1);
    do_ack(37, "R9 line5");
    do_eoi();
    chk("R9 all idle", irq_out, 0);

    // R10 base reprogramming and wrap
    wr_base = 1'b1; base_din = 8'd250; step(); wr_base = 1'b0;
    pulse(8'h40);
    do_ack(0, "R10 wrap");
    do_eoi();
    pulse(8'h02);
    do_ack(251, "R10 base");
    do_eoi();

    // R6 ack with nothing pending has no effect
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 idle ack no vector", vec_valid, 0);
    pulse(8'h01);
    do_ack(250, "R6 after idle ack");
    do_eoi();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule